// File: doc/BRIEF.md
# Sticky Interrupt Aggregator with Masking

This block gathers eight single-cycle event pulses from the engines of a radio transceiver. The pulses cover sleep, wake, half-symbol timer, security, receive, two guaranteed-time-slot transmit events and normal transmit. Each pulse sets a sticky flag in a status register. The flags stay set until the host reads the status word, and that read clears them. The host must therefore handle every flag that a read returns.

A mask register stops chosen sources from reaching the single interrupt pin. Masking does not stop a source from setting its flag. A polarity bit selects whether the pin is active high or active low. The pin is registered. It holds its active level while any set flag is unmasked. No priority or vector is provided, so the host checks each status bit to find out which sources fired.

Top module: `irq_collector`

## Requirements
- R1: After reset, every status flag is 0, every mask bit is 1, the polarity is active-low and `irq_o` is 1 (inactive).
- R2: A 1 on `evt_i[k]` sets status bit k at the next clock edge, and the bit stays set until a read. The bit order from bit 0 upward is: transmit, slot-1 transmit, slot-2 transmit, receive, security, half-symbol timer, wake, sleep.
- R3: `rd_data` always shows the current status word. A cycle with `rd_en` high returns that word and clears the flags at the next edge.
- R4: An event that arrives in the same cycle as a read is kept. After the clear, its flag is set.
- R5: A masked source still sets its status flag and can be read, but it does not assert `irq_o`.
- R6: `irq_o` is active exactly when some status flag is set while its mask bit is 0. It follows a change in a flag, the mask or the polarity one clock later.
- R7: Polarity value 1 makes `irq_o` active high. Value 0 makes it active low.
- R8: `irq_o` returns to inactive once every enabled flag has been cleared or masked off.
- R9: `mask_we` loads `mask_wdata` into the mask register, and `pol_we` loads `pol_wdata` into the polarity bit. A mask bit of 1 blocks its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event pulses, one bit per source |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask value (1 blocks the source) |
| pol_we | input | 1 | Polarity write strobe |
| pol_wdata | input | 1 | New polarity (1 = active high) |
| rd_en | input | 1 | Status read strobe; clears the flags at the next edge |
| rd_data | output | 8 | Current status flags |
| irq_o | output | 1 | Combined interrupt pin |

## Verification
The assertions assume that every input is a clean level sampled at the rising edge. They also assume that an event is a plain one-cycle pulse and not a request to clear. They place no limit on how a read, an event and a mask or polarity write may overlap in the same cycle. The random stimulus therefore drives all of these in any combination: events are sparse, and reads and writes occur at independent rates. Directed steps add the case where a read and an event arrive together, and the case where a flag is set while its source is masked.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            pol_we,
  input  logic            pol_wdata,
  input  logic            rd_en,
  output logic [NSRC-1:0] rd_data,
  output logic            irq_o
);

  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] mask_q;
  logic            pol_q;
  logic            irq_q;
  logic            pending;

  assign pending = |(status_q & ~mask_q);
  assign rd_data = status_q;
  assign irq_o   = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
      pol_q    <= 1'b0;
      irq_q    <= 1'b1;
    end else begin
      status_q <= (rd_en ? '0 : status_q) | evt_i;
      if (mask_we) mask_q <= mask_wdata;
      if (pol_we)  pol_q  <= pol_wdata;
      irq_q    <= pol_q ? pending : ~pending;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

  AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (status_q == $past(evt_i))); // R3

  AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> (irq_o == $past(pol_q))); // R6

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> (irq_o != $past(pol_q))); // R8

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata))); // R9

endmodule

// File: tb/irq_collector_test.sv
module irq_collector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       pol_we = 1'b0;
  logic       pol_wdata = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] st_m;
  logic [7:0] mask_m;
  logic       pol_m;
  logic       irq_m;

  always #10 clk = ~clk;

  irq_collector uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .pol_we(pol_we), .pol_wdata(pol_wdata),
    .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o)
  );

  function automatic logic exp_irq(logic [7:0] st, logic [7:0] mk, logic pl);
    logic any;
    any = |(st & ~mk);
    return pl ? any : ~any;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [7:0] ev, logic rd, logic mwe,
                      logic [7:0] mwd, logic pwe, logic pwd);
    evt_i = ev; rd_en = rd; mask_we = mwe; mask_wdata = mwd;
    pol_we = pwe; pol_wdata = pwd;
    @(posedge clk);
    irq_m = exp_irq(st_m, mask_m, pol_m);
    st_m  = (rd ? 8'h00 : st_m) | ev;
    if (mwe) mask_m = mwd;
    if (pwe) pol_m = pwd;
    @(negedge clk);
    evt_i = '0; rd_en = 1'b0; mask_we = 1'b0; pol_we = 1'b0;
    chk(tag, rd_data, st_m);
    chk(tag, {7'b0, irq_o}, {7'b0, irq_m});
  endtask

  initial begin
    void'($urandom(32'd7531));
    st_m = '0; mask_m = '1; pol_m = 1'b0; irq_m = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", rd_data, 8'h00);
    chk("R1", {7'b0, irq_o}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {7'b0, irq_o}, 8'h01);
    // walk each source bit: sticky accumulation while masked (R2, R5)
    for (int i = 0; i < 8; i++) step("R2", 8'h01 << i, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R5", rd_data, 8'hFF);
    chk("R5", {7'b0, irq_o}, 8'h01);
    step("R3", 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R3", rd_data, 8'h00);
    // unmask all, raise receive flag, pin goes low a cycle later (R6, R9)
    step("R9", 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    step("R6", 8'h08, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    step("R6", 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R6", {7'b0, irq_o}, 8'h00);
    // switch to active-high (R7)
    step("R7", 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    step("R7", 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R7", {7'b0, irq_o}, 8'h01);
    // mask off the receive source: pin falls inactive (R8)
    step("R8", 8'h00, 1'b0, 1'b1, 8'h08, 1'b0, 1'b0);
    step("R8", 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R8", {7'b0, irq_o}, 8'h00);
    chk("R5", rd_data, 8'h08);
    // event coincident with a read survives (R4)
    step("R4", 8'h21, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R4", rd_data, 8'h21);
    step("R8", 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    step("R8", 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R8", {7'b0, irq_o}, 8'h00);
    // constrained random mix (R6)
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] ev;
      ev = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      if (($urandom % 16) == 0) ev = 8'($urandom);
      step("R6", ev, ($urandom % 6) == 0, ($urandom % 10) == 0, 8'($urandom),
           ($urandom % 25) == 0, 1'($urandom));
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule